// File: doc/BRIEF.md
# Latched Fault Protection Controller

This block guards the power stage of a two-phase stepper motor. It watches two detector inputs: an overcurrent comparator and an overtemperature sensor. It passes the requested gate drive through to the switches only while neither fault is held. After every turn-on of the chopper, the overcurrent input is masked for a blanking window. This keeps the ringing at switch-on from being read as a fault.

A fault that is detected is held in a latch. While the latch is set, every gate output is forced off. Two outputs report the fault:
- an active-low summary flag that is low whenever any fault is held;
- a two-bit code that says which fault, or both, was seen.

Only the clear input held low, or the asynchronous power-on reset, releases the latch. If a fault input is still active when the clear is released, the latch sets again. After any reset, step pulses are blocked for a hold-off interval.

Top module: `fault_guard`

## Requirements
- R1: After each rising edge of `chop_en` the overcurrent input is ignored for BLANK_CYC clock cycles, where BLANK_CYC is BLANK_NS rounded up to whole cycles of CLK_HZ. A new rising edge restarts the window.
- R2: An overcurrent seen while `chop_en` is high, after the window has expired, latches on the next clock edge.
- R3: An overtemperature input latches on the next clock edge. It does not depend on `chop_en` or on blanking.
- R4: While any fault is latched, `gate_out` is all zeros whatever `gate_req` and `chop_en` are.
- R5: `flt_n` is 0 while any fault is latched. It stays 0 after the detector inputs return low.
- R6: In `flt_code`, bit 0 means an overcurrent was latched and bit 1 means an overtemperature was latched. The value 2'b11 means both, and 2'b00 means no fault.
- R7: Only `clr_n` low or `por_n` low clears the latch. Changes on `gate_req` or `chop_en` leave it set.
- R8: If a detector input is still active when `clr_n` returns high, the fault latches again on the first clock edge after the release.
- R9: `step_out` is held at 0 for HOLD_CYC clock cycles after `por_n` or `clr_n` is released. HOLD_CYC is HOLDOFF_NS rounded up to whole cycles. After that window, `step_out` follows `step_in`.
- R10: With no fault latched and `clr_n` high, `gate_out` equals `gate_req` while `chop_en` is 1, and is 0 while `chop_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n | input | 1 | Synchronous fault clear, active low |
| chop_en | input | 1 | Chopper conduction enable; a rising edge marks a turn-on |
| gate_req | input | GATES | Requested gate drive per switch |
| oc_det | input | 1 | Overcurrent comparator output |
| ot_det | input | 1 | Overtemperature sensor output |
| step_in | input | 1 | Step pulse from the sequencer |
| gate_out | output | GATES | Gate drive to the power switches |
| step_out | output | 1 | Step pulse after the reset hold-off |
| flt_n | output | 1 | Summary fault flag, active low |
| flt_code | output | 2 | Fault type: bit 0 overcurrent, bit 1 overtemperature |

## Verification
The gate path is checked across all sixteen request patterns, with the chopper both on and off. This separates plain pass-through from masking by the enable.

Overcurrent is applied in three ways:
- inside a window that was restarted by a second turn-on;
- held from a turn-on, sampled one cycle before and one cycle at the expected latch edge;
- together with overtemperature in the same cycle.

Together these separate a missing blanking window, a window that is not restarted, an off-by-one window length, and a merged fault code. Clear pulses with and without a fault input still active show the difference between a true release and immediate re-latching. The step hold-off is sampled one cycle on each side of its end, after both kinds of reset.

// File: rtl/fault_guard.sv
module fault_guard #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BLANK_NS   = 1250,
  parameter int HOLDOFF_NS = 10_000,
  parameter int GATES      = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr_n,
  input  logic             chop_en,
  input  logic [GATES-1:0] gate_req,
  input  logic             oc_det,
  input  logic             ot_det,
  input  logic             step_in,
  output logic [GATES-1:0] gate_out,
  output logic             step_out,
  output logic             flt_n,
  output logic [1:0]       flt_code
);
  localparam int BLANK_CYC = (CLK_HZ / 1000 * BLANK_NS + 999_999) / 1_000_000;
  localparam int HOLD_CYC  = (CLK_HZ / 1000 * HOLDOFF_NS + 999_999) / 1_000_000;
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic          chop_q;
  logic [BW-1:0] blank_cnt;
  logic [HW-1:0] hold_cnt;
  logic          oc_lat, ot_lat;
  logic          turn_on, oc_window, tripped;

  assign turn_on   = chop_en & ~chop_q;
  assign oc_window = chop_en & ~turn_on & (blank_cnt == '0);
  assign tripped   = oc_lat | ot_lat;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      chop_q    <= 1'b0;
      blank_cnt <= '0;
    end else begin
      chop_q <= chop_en;
      if (turn_on)
        blank_cnt <= BW'(BLANK_CYC);
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      oc_lat <= 1'b0;
      ot_lat <= 1'b0;
    end else if (!clr_n) begin
      oc_lat <= 1'b0;
      ot_lat <= 1'b0;
    end else begin
      oc_lat <= oc_lat | (oc_det & oc_window);
      ot_lat <= ot_lat | ot_det;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      hold_cnt <= HW'(HOLD_CYC);
    else if (!clr_n)
      hold_cnt <= HW'(HOLD_CYC);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
  end

  assign gate_out = (tripped | ~clr_n) ? '0 : (gate_req & {GATES{chop_en}});
  assign step_out = step_in & (hold_cnt == '0) & clr_n;
  assign flt_n    = ~tripped;
  assign flt_code = {ot_lat, oc_lat};

  assert_blank_R1: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(chop_en) && clr_n) |=> (flt_code[0] == $past(flt_code[0])));

  assert_oc_source_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flt_code[0]) |-> ($past(oc_det) && $past(chop_en)));

  assert_ot_latch_R3: assert property (@(posedge clk) disable iff (!por_n)
    (ot_det && clr_n) |=> (flt_code[1] && !flt_n));

  assert_gates_off_R4: assert property (@(posedge clk) disable iff (!por_n)
    (ot_det && clr_n) |=> (gate_out == '0));

  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!por_n)
    (!flt_n && clr_n) |=> !flt_n);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!por_n)
    !clr_n |=> (flt_n && flt_code == 2'b00));

  assert_holdoff_R9: assert property (@(posedge clk) disable iff (!por_n)
    !clr_n |=> !step_out);
endmodule

// File: tb/fault_guard_tb_top.sv
module fault_guard_tb_top;
  localparam int CLK_HZ = 50_000_000;
  localparam int BLANK  = (CLK_HZ / 1000 * 1250 + 999_999) / 1_000_000;
  localparam int HOLD   = (CLK_HZ / 1000 * 10_000 + 999_999) / 1_000_000;

  logic clk = 1'b0;
  logic por_n, clr_n, chop_en, oc_det, ot_det, step_in;
  logic [3:0] gate_req, gate_out;
  logic step_out, flt_n;
  logic [1:0] flt_code;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  fault_guard dut_i (
    .clk(clk), .por_n(por_n), .clr_n(clr_n), .chop_en(chop_en),
    .gate_req(gate_req), .oc_det(oc_det), .ot_det(ot_det), .step_in(step_in),
    .gate_out(gate_out), .step_out(step_out), .flt_n(flt_n), .flt_code(flt_code)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200_000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    por_n = 1'b0; clr_n = 1'b1; chop_en = 1'b0; oc_det = 1'b0; ot_det = 1'b0;
    step_in = 1'b1; gate_req = 4'h0;
    tick(3);
    por_n = 1'b1;
    #1;
    chk("reset flt_n", flt_n, 1);
    chk("reset flt_code", flt_code, 0);
    chk("reset gate_out", gate_out, 0);
    chk("R9 step after por", step_out, 0);
    tick(HOLD - 1);
    chk("R9 step one before end (por)", step_out, 0);
    tick(2);
    chk("R9 step after holdoff (por)", step_out, 1);

    // R10 sweep of gate patterns
    for (int c = 0; c < 2; c++)
      for (int g = 0; g < 16; g++) begin
        chop_en = c[0]; gate_req = g[3:0];
        #1;
        chk("R10 gate pass", gate_out, c ? g : 0);
        tick(1);
      end

    // R1 restart: second turn-on restarts window
    chop_en = 1'b0; tick(1);
    chop_en = 1'b1; tick(BLANK - 5);
    chop_en = 1'b0; tick(1);
    chop_en = 1'b1; oc_det = 1'b1; tick(BLANK);
    oc_det = 1'b0; tick(2);
    chk("R1 restarted window masks oc", flt_n, 1);

    // R1/R2 exact latch edge
    chop_en = 1'b0; tick(1);
    chop_en = 1'b1; oc_det = 1'b1; gate_req = 4'hF;
    tick(BLANK + 1);
    chk("R1 oc masked through window", flt_n, 1);
    tick(1);
    chk("R2 oc latched after window", flt_n, 0);
    chk("R6 oc code", flt_code, 2'b01);
    chk("R4 gates off on fault", gate_out, 0);
    oc_det = 1'b0; tick(5);
    chk("R5 flag held after input drops", flt_n, 0);
    chop_en = 1'b0; gate_req = 4'h5; tick(2);
    chop_en = 1'b1; tick(2);
    chk("R7 no clear by chop/gate changes", flt_code, 2'b01);
    chk("R4 gates still off", gate_out, 0);

    // clear and holdoff
    clr_n = 1'b0; tick(1);
    chk("R7 clear releases latch", {flt_n, flt_code}, 3'b100);
    chk("R9 step blocked during clear", step_out, 0);
    clr_n = 1'b1;
    tick(HOLD - 1);
    chk("R9 step one before end (clr)", step_out, 0);
    tick(2);
    chk("R9 step after holdoff (clr)", step_out, 1);
    chk("R10 gates back on", gate_out, 4'h5);

    // R3 overtemperature, independent of chop
    chop_en = 1'b0; ot_det = 1'b1; tick(1);
    chk("R3 ot latched", flt_n, 0);
    chk("R6 ot code", flt_code, 2'b10);
    ot_det = 1'b0; clr_n = 1'b0; tick(1);
    clr_n = 1'b1; tick(1);
    chk("R7 cleared after ot", flt_n, 1);

    // R6 both at once
    chop_en = 1'b1; tick(BLANK + 5);
    oc_det = 1'b1; ot_det = 1'b1; tick(1);
    chk("R6 both code", flt_code, 2'b11);

    // R8 re-latch with inputs still present
    clr_n = 1'b0; tick(1);
    chk("R8 clear while held", flt_n, 1);
    clr_n = 1'b1; tick(1);
    chk("R8 relatch at release", flt_code, 2'b11);
    oc_det = 1'b0; ot_det = 1'b0;
    clr_n = 1'b0; tick(1);
    clr_n = 1'b1; tick(2);
    chk("R8 stays clear when inputs gone", flt_n, 1);

    summary();
  end
endmodule